// File: doc/BRIEF.md
# Carry-Aware Integer ALU

This block is the execute-stage arithmetic and logic unit of a small microcontroller-style core. It works on 32-bit data and holds the core's carry flag in a register. The first operand always comes from a register. The second operand is either a second register value or an 8-bit immediate that is zero-extended, and an immediate-select bit chooses between them. The operation arrives already decoded as a 5-bit code. The result and the next carry value are produced combinationally in the same cycle.

Subtraction follows a no-borrow convention. After a subtract, the carry flag is 1 when no borrow occurred. The with-carry subtract forms take away the inverse of the flag, so that multi-word subtraction chains correctly. Reverse-subtract forms swap the roles of the two operands. A leftmost-match scan returns the highest bit position of the first operand that equals bit 0 of the second operand.

The carry register loads the next carry value on a clock edge only when a valid strobe accompanies an arithmetic operation. Every other operation passes the current flag through unchanged.

Top module: `carry_alu`

## Requirements
- R1: The second operand is the 8-bit immediate, zero-extended to 32 bits, when `imm_sel_i` is 1, and `rs2_i` when it is 0.
- R2: ADD (code 0) gives first + second modulo 2^32, and `carry_next_o` is bit 32 of the unsigned sum.
- R3: ADC (code 1) gives first + second + carry, and `carry_next_o` is bit 32 of that three-term sum.
- R4: SUB (code 2) gives first − second, and `carry_next_o` is 1 exactly when first ≥ second (unsigned), so that it signals no borrow.
- R5: SUC (code 3) gives first − second − (1 − carry), and `carry_next_o` is 1 exactly when that subtraction needs no borrow.
- R6: RSB (code 4) and RSC (code 5) do the same as SUB and SUC with the two operands swapped, that is second − first.
- R7: LSL (code 6) and LSR (code 7) shift the first operand logically by the low 5 bits of the second operand.
- R8: AND (8), OR (9) and XOR (10) combine the two operands bitwise. NOT (11) gives the inverse of the first operand and ignores both the second operand and `imm_sel_i`.
- R9: MIN (12) and MAX (13) return the smaller or larger operand under an unsigned comparison.
- R10: CLR (14) and SET (15) clear or set the bit of the first operand whose index is the low 5 bits of the second operand.
- R11: LMBD (16) returns the highest bit index of the first operand whose value equals bit 0 of the second operand, or 32 when no bit matches.
- R12: The carry flag resets to 0. On a clock edge it loads `carry_next_o` when `valid_i` is 1 and the code is 0 to 5. Otherwise it holds its value. For codes other than 0 to 5, `carry_next_o` equals the current flag.
- R13: Codes 17 to 31 are undefined. They give a result of 0 and leave the carry flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe; allows the carry register to update |
| op_i | input | 5 | Decoded operation code |
| imm_sel_i | input | 1 | 1 selects the immediate as the second operand |
| rs1_i | input | 32 | First operand |
| rs2_i | input | 32 | Second register operand |
| imm8_i | input | 8 | 8-bit immediate |
| result_o | output | 32 | Operation result |
| carry_next_o | output | 1 | Carry value the operation would store |
| carry_o | output | 1 | Registered carry flag |

## Verification
The assertions assume that the operation code, the operands and the strobe are known and steady around each rising clock edge, because they relate the carry flag after an edge to the inputs sampled at that edge. The stimulus changes all inputs only on the falling edge and holds them for a full cycle. The bench sets up a required carry state with a separate ADD cycle before each table vector, so the with-carry and hold cases always start from a known flag.

// File: rtl/carry_alu_pkg.sv
package carry_alu_pkg;

  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUC  = 5'd3,
    OP_RSB  = 5'd4,
    OP_RSC  = 5'd5,
    OP_LSL  = 5'd6,
    OP_LSR  = 5'd7,
    OP_AND  = 5'd8,
    OP_OR   = 5'd9,
    OP_XOR  = 5'd10,
    OP_NOT  = 5'd11,
    OP_MIN  = 5'd12,
    OP_MAX  = 5'd13,
    OP_CLR  = 5'd14,
    OP_SET  = 5'd15,
    OP_LMBD = 5'd16
  } op_e;

  // Arithmetic codes are the only ones that write the carry flag.
  function automatic logic op_is_arith(input logic [OPW-1:0] op);
    return (op <= OP_RSC);
  endfunction

endpackage

// File: rtl/cal_operand_mux.sv
module cal_operand_mux #(
  parameter int W  = 32,
  parameter int IMMW = 8
) (
  input  logic            imm_sel,
  input  logic [W-1:0]    reg_val,
  input  logic [IMMW-1:0] imm_val,
  output logic [W-1:0]    opnd
);
  assign opnd = imm_sel ? {{(W-IMMW){1'b0}}, imm_val} : reg_val;
endmodule

// File: rtl/cal_addsub.sv
module cal_addsub
  import carry_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   sum,
  output logic           cout
);
  logic [W-1:0] x, y;
  logic         ci;
  logic [W:0]   full;

  // x - y - !c is computed as x + ~y + c; its carry out is the no-borrow flag.
  always_comb begin
    x  = a;
    y  = b;
    ci = 1'b0;
    case (op_e'(op))
      OP_ADD: begin x = a; y = b;  ci = 1'b0; end
      OP_ADC: begin x = a; y = b;  ci = cin;  end
      OP_SUB: begin x = a; y = ~b; ci = 1'b1; end
      OP_SUC: begin x = a; y = ~b; ci = cin;  end
      OP_RSB: begin x = b; y = ~a; ci = 1'b1; end
      OP_RSC: begin x = b; y = ~a; ci = cin;  end
      default: begin x = a; y = b; ci = 1'b0; end
    endcase
  end

  assign full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  assign sum  = full[W-1:0];
  assign cout = full[W];
endmodule

// File: rtl/cal_lead_scan.sv
module cal_lead_scan #(
  parameter int W  = 32,
  parameter int IW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  input  logic          want,
  output logic [IW-1:0] idx
);
  // Ascending sweep: the last match written is the highest one.
  always_comb begin
    idx = IW'(W);
    for (int i = 0; i < W; i++) begin
      if (val[i] == want) idx = IW'(i);
    end
  end
endmodule

// File: rtl/cal_bitops.sv
module cal_bitops
  import carry_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res,
  output logic           hit
);
  localparam int SHW = $clog2(W);

  logic [SHW-1:0] amt;
  logic [W-1:0]   onehot;

  assign amt    = b[SHW-1:0];
  assign onehot = {{(W-1){1'b0}}, 1'b1} << amt;

  always_comb begin
    hit = 1'b1;
    case (op_e'(op))
      OP_LSL: res = a << amt;
      OP_LSR: res = a >> amt;
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_NOT: res = ~a;
      OP_MIN: res = (a < b) ? a : b;
      OP_MAX: res = (a > b) ? a : b;
      OP_CLR: res = a & ~onehot;
      OP_SET: res = a | onehot;
      default: begin res = '0; hit = 1'b0; end
    endcase
  end
endmodule

// File: rtl/carry_alu.sv
module carry_alu
  import carry_alu_pkg::*;
#(
  parameter int W    = 32,
  parameter int IMMW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [OPW-1:0]   op_i,
  input  logic             imm_sel_i,
  input  logic [W-1:0]     rs1_i,
  input  logic [W-1:0]     rs2_i,
  input  logic [IMMW-1:0]  imm8_i,
  output logic [W-1:0]     result_o,
  output logic             carry_next_o,
  output logic             carry_o
);
  localparam int IW = $clog2(W + 1);

  logic [W-1:0]  op2_w;
  logic [W-1:0]  arith_sum_w;
  logic          arith_cout_w;
  logic [W-1:0]  bit_res_w;
  logic          bit_hit_w;
  logic [IW-1:0] lead_idx_w;
  logic          is_arith_w;
  logic          is_lead_w;
  logic          carry_q;

  cal_operand_mux #(.W(W), .IMMW(IMMW)) u_opnd (
    .imm_sel (imm_sel_i),
    .reg_val (rs2_i),
    .imm_val (imm8_i),
    .opnd    (op2_w)
  );

  cal_addsub #(.W(W)) u_addsub (
    .op   (op_i),
    .a    (rs1_i),
    .b    (op2_w),
    .cin  (carry_q),
    .sum  (arith_sum_w),
    .cout (arith_cout_w)
  );

  cal_bitops #(.W(W)) u_bitops (
    .op  (op_i),
    .a   (rs1_i),
    .b   (op2_w),
    .res (bit_res_w),
    .hit (bit_hit_w)
  );

  cal_lead_scan #(.W(W), .IW(IW)) u_scan (
    .val  (rs1_i),
    .want (op2_w[0]),
    .idx  (lead_idx_w)
  );

  assign is_arith_w = op_is_arith(op_i);
  assign is_lead_w  = (op_i == OP_LMBD);

  always_comb begin
    if (is_arith_w)     result_o = arith_sum_w;
    else if (is_lead_w) result_o = {{(W-IW){1'b0}}, lead_idx_w};
    else if (bit_hit_w) result_o = bit_res_w;
    else                result_o = '0;
  end

  assign carry_next_o = is_arith_w ? arith_cout_w : carry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       carry_q <= 1'b0;
    else if (valid_i && is_arith_w)   carry_q <= arith_cout_w;
  end

  assign carry_o = carry_q;
endmodule

// File: rtl/carry_alu_chk.sv
module carry_alu_chk
  import carry_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           valid_i,
  input logic [OPW-1:0] op_i,
  input logic [W-1:0]   rs1_i,
  input logic [W-1:0]   op2_w,
  input logic           is_arith_w,
  input logic [W-1:0]   result_o,
  input logic           carry_next_o,
  input logic           carry_o
);
  a_r12_load: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && is_arith_w) |=> (carry_o == $past(carry_next_o)));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i || !is_arith_w) |=> $stable(carry_o));

  a_r12_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    !is_arith_w |-> (carry_next_o == carry_o));

  a_r4_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SUB) |-> (carry_next_o == (rs1_i >= op2_w)));

  a_r9_min_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_MIN) |-> (result_o <= rs1_i && result_o <= op2_w));

  a_r9_max_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_MAX) |-> (result_o >= rs1_i && result_o >= op2_w));

  a_r11_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_LMBD) |-> (result_o <= W[W-1:0]));

  a_r13_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i > 5'd16) |-> (result_o == '0));
endmodule

bind carry_alu carry_alu_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .valid_i      (valid_i),
  .op_i         (op_i),
  .rs1_i        (rs1_i),
  .op2_w        (op2_w),
  .is_arith_w   (is_arith_w),
  .result_o     (result_o),
  .carry_next_o (carry_next_o),
  .carry_o      (carry_o)
);

// File: tb/carry_alu_tb.sv
`timescale 1ns/1ps
module carry_alu_tb;
  import carry_alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic        imm_sel_i = 1'b0;
  logic [31:0] rs1_i = '0;
  logic [31:0] rs2_i = '0;
  logic [7:0]  imm8_i = '0;
  logic [31:0] result_o;
  logic        carry_next_o;
  logic        carry_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  carry_alu u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .imm_sel_i(imm_sel_i), .rs1_i(rs1_i), .rs2_i(rs2_i), .imm8_i(imm8_i),
    .result_o(result_o), .carry_next_o(carry_next_o), .carry_o(carry_o)
  );

  typedef struct packed {
    logic [4:0]  op;
    logic        sel;
    logic        cin;
    logic [31:0] a;
    logic [31:0] b;
    logic [7:0]  imm;
    logic [31:0] res;
    logic        c;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{5'd0,  1'b0, 1'b0, 32'hFFFFFFFF, 32'h00000001, 8'h00, 32'h00000000, 1'b1, 4'd2},  // R2
    '{5'd0,  1'b1, 1'b1, 32'h00000010, 32'h0000FFFF, 8'h05, 32'h00000015, 1'b0, 4'd1},  // R1
    '{5'd1,  1'b0, 1'b1, 32'hFFFFFFFF, 32'h00000000, 8'h00, 32'h00000000, 1'b1, 4'd3},  // R3
    '{5'd1,  1'b0, 1'b1, 32'h00000001, 32'h00000002, 8'h00, 32'h00000004, 1'b0, 4'd3},
    '{5'd2,  1'b0, 1'b0, 32'h00000005, 32'h00000005, 8'h00, 32'h00000000, 1'b1, 4'd4},  // R4
    '{5'd2,  1'b0, 1'b1, 32'h00000003, 32'h00000005, 8'h00, 32'hFFFFFFFE, 1'b0, 4'd4},
    '{5'd3,  1'b0, 1'b0, 32'h00000005, 32'h00000005, 8'h00, 32'hFFFFFFFF, 1'b0, 4'd5},  // R5
    '{5'd3,  1'b0, 1'b1, 32'h00000005, 32'h00000005, 8'h00, 32'h00000000, 1'b1, 4'd5},
    '{5'd4,  1'b1, 1'b0, 32'h00000002, 32'hDEAD0000, 8'h07, 32'h00000005, 1'b1, 4'd6},  // R6
    '{5'd5,  1'b0, 1'b0, 32'h00000001, 32'h00000001, 8'h00, 32'hFFFFFFFF, 1'b0, 4'd6},
    '{5'd5,  1'b0, 1'b1, 32'h00000001, 32'h00000003, 8'h00, 32'h00000002, 1'b1, 4'd6},
    '{5'd6,  1'b0, 1'b1, 32'h00000001, 32'h00000023, 8'h00, 32'h00000008, 1'b1, 4'd7},  // R7
    '{5'd7,  1'b1, 1'b0, 32'h80000000, 32'h00000000, 8'hFF, 32'h00000001, 1'b0, 4'd7},
    '{5'd8,  1'b0, 1'b1, 32'hF0F0F0F0, 32'hFF00FF00, 8'h00, 32'hF000F000, 1'b1, 4'd8},  // R8
    '{5'd9,  1'b0, 1'b0, 32'hF0F0F0F0, 32'hFF00FF00, 8'h00, 32'hFFF0FFF0, 1'b0, 4'd8},
    '{5'd10, 1'b0, 1'b1, 32'hF0F0F0F0, 32'hFF00FF00, 8'h00, 32'h0FF00FF0, 1'b1, 4'd8},
    '{5'd11, 1'b1, 1'b0, 32'h12345678, 32'h00000000, 8'hFF, 32'hEDCBA987, 1'b0, 4'd8},
    '{5'd11, 1'b0, 1'b1, 32'h12345678, 32'hFFFFFFFF, 8'h00, 32'hEDCBA987, 1'b1, 4'd8},
    '{5'd12, 1'b0, 1'b0, 32'h80000000, 32'h00000001, 8'h00, 32'h00000001, 1'b0, 4'd9},  // R9
    '{5'd13, 1'b0, 1'b1, 32'h80000000, 32'h00000001, 8'h00, 32'h80000000, 1'b1, 4'd9},
    '{5'd14, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h00000000, 8'h24, 32'hFFFFFFEF, 1'b0, 4'd10}, // R10
    '{5'd15, 1'b0, 1'b1, 32'h00000000, 32'h0000003F, 8'h00, 32'h80000000, 1'b1, 4'd10},
    '{5'd16, 1'b0, 1'b0, 32'h0000F000, 32'h00000001, 8'h00, 32'h0000000F, 1'b0, 4'd11}, // R11
    '{5'd16, 1'b1, 1'b1, 32'hFFFFFFFF, 32'h00000000, 8'h00, 32'h00000020, 1'b1, 4'd11},
    '{5'd16, 1'b1, 1'b0, 32'h7FFFFFFF, 32'h00000000, 8'hFE, 32'h0000001F, 1'b0, 4'd11},
    '{5'd20, 1'b0, 1'b1, 32'h00000001, 32'h00000001, 8'h00, 32'h00000000, 1'b1, 4'd13}, // R13
    '{5'd2,  1'b1, 1'b0, 32'h000000FF, 32'h00000000, 8'hFF, 32'h00000000, 1'b1, 4'd1}   // R1 zero-extension
  };

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive an ADD that leaves the flag at c.
  task automatic set_carry(input logic c);
    @(negedge clk);
    valid_i = 1'b1; op_i = 5'd0; imm_sel_i = 1'b0;
    rs1_i = c ? 32'hFFFFFFFF : 32'h0; rs2_i = c ? 32'h1 : 32'h0;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(carry_o == 1'b0, 12, "carry in reset", 32'(carry_o), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(carry_o == 1'b0, 12, "carry after reset", 32'(carry_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      set_carry(VECS[i].cin);
      valid_i = 1'b1; op_i = VECS[i].op; imm_sel_i = VECS[i].sel;
      rs1_i = VECS[i].a; rs2_i = VECS[i].b; imm8_i = VECS[i].imm;
      #1;
      check(result_o == VECS[i].res, VECS[i].req, $sformatf("vec %0d result", i),
            result_o, VECS[i].res);
      check(carry_next_o == VECS[i].c, VECS[i].req, $sformatf("vec %0d carry_next", i),
            32'(carry_next_o), 32'(VECS[i].c));
      @(posedge clk); #1;
      // R12: stored flag follows carry_next for arithmetic, holds otherwise
      check(carry_o == VECS[i].c, 12, $sformatf("vec %0d carry_o", i),
            32'(carry_o), 32'(VECS[i].c));
      @(negedge clk);
      valid_i = 1'b0;
    end

    // R12: overflowing ADD without valid leaves the flag at 0
    set_carry(1'b0);
    op_i = 5'd0; rs1_i = 32'hFFFFFFFF; rs2_i = 32'h1; imm_sel_i = 1'b0;
    #1;
    check(carry_next_o == 1'b1, 2, "carry_next without valid", 32'(carry_next_o), 32'h1);
    @(posedge clk); #1;
    check(carry_o == 1'b0, 12, "no load without valid", 32'(carry_o), 32'h0);

    // R12: reset in mid-run clears a set flag
    set_carry(1'b1);
    check(carry_o == 1'b1, 12, "flag set before reset", 32'(carry_o), 32'h1);
    rst_n = 1'b0;
    #1;
    check(carry_o == 1'b0, 12, "async reset clears flag", 32'(carry_o), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule